// File: doc/BRIEF.md
# Peripheral clock and reset sequencer

This block takes one peripheral through a controlled restart by driving a system-control block. The system-control block gates the peripheral clock and holds its reset. Each control is a pair of write-one registers, one to set and one to clear, and each has a read-only status register. A single start pulse launches four steps in a fixed order: assert reset, stop the clock, release reset, restart the clock. Every step writes a 1 to one control register and then polls the matching status register until bit 0 reaches the level that step expects. Only then does the next step begin.

A step fails when its status has not reached the expected level within a configurable number of polls. The sequence then stops at once and reports which step failed. Success and failure are shown on separate flags. Each flag stays up until the next accepted start. Toward the system-control block the sequencer is a plain bus master: a one-cycle write strobe, a one-cycle read strobe, and a read-data-valid return. At most one read is in flight at a time.

Top module: `prst_seq`

## Requirements
- R1: After reset, `busy_o`, `done_o`, `err_o`, `bus_wr_o` and `bus_rd_o` are all 0.
- R2: A `start_i` pulse while idle raises `busy_o` in the next cycle and clears `done_o` and `err_o`. The sequence then issues exactly four writes, each with data value 1, in this order: reset request, clock disable, reset release, clock enable. No bus strobe is issued while idle.
- R3: The clock-enable and reset-request addresses are parameters (defaults 0x338 and 0xA38). Clock disable is always clock enable + 4 and reset release is always reset request + 4. Steps 1 and 3 poll the reset status address (default 0x5A1C). Steps 2 and 4 poll the clock status address (default 0x531C).
- R4: A step's write is followed by a read in the next cycle. The next step's write is issued only after a read has returned bit 0 at the expected level: 1, 0, 0, 1 for steps 1 to 4. Each step issues exactly as many reads as it needs to see that level.
- R5: A step that sees no match within `POLL_LIMIT` completed reads ends the sequence with `err_o`=1. No further write or read is issued after that.
- R6: A match on exactly the `POLL_LIMIT`-th read counts as success, not timeout.
- R7: On failure, `err_step_o` gives the failing step: 0 = reset assert, 1 = clock off, 2 = reset release, 3 = clock on.
- R8: A `start_i` pulse while `busy_o`=1 is ignored. The running sequence continues unchanged and no extra writes occur.
- R9: `done_o` and `err_o` are never both 1. After a sequence ends, both keep their values until the next accepted start.
- R10: A new read is never issued while a previous read has not yet returned `bus_rvalid_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start pulse |
| busy_o | output | 1 | Sequence running |
| done_o | output | 1 | Last sequence completed all four steps |
| err_o | output | 1 | Last sequence aborted on timeout |
| err_step_o | output | 2 | Step that timed out |
| bus_wr_o | output | 1 | One-cycle write strobe |
| bus_rd_o | output | 1 | One-cycle read strobe |
| bus_addr_o | output | AW | Byte address for write or read |
| bus_wdata_o | output | DW | Write data (always 1) |
| bus_rvalid_i | input | 1 | Read data valid |
| bus_rdata_i | input | DW | Read data; bit 0 is the status bit |

## Verification
A single read completion can carry both a status match and the expiry of the poll budget. The bench's system-control model is therefore set up so that the expected level first appears on exactly the `POLL_LIMIT`-th read of every step. The result is judged correct only if the run ends with done raised, the error flag low and all four writes issued. The same model, with the level delayed by one more read, must instead end in a timeout at the chosen step, with the write count cut short there.

// File: rtl/prst_pkg.sv
package prst_pkg;

    typedef enum logic [1:0] {
        STEP_RST_ON  = 2'd0,
        STEP_CLK_OFF = 2'd1,
        STEP_RST_OFF = 2'd2,
        STEP_CLK_ON  = 2'd3
    } step_e;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_WRITE,
        PH_RD_REQ,
        PH_RD_WAIT
    } phase_e;

    // Per-step decode: which control pair, set or clear register, target level
    typedef struct packed {
        logic clk_side;
        logic clear_reg;
        logic want;
    } step_info_t;

    localparam int unsigned CLR_OFFSET = 4;

    function automatic step_info_t step_info(step_e s);
        step_info_t r;
        case (s)
            STEP_RST_ON:  r = '{clk_side: 1'b0, clear_reg: 1'b0, want: 1'b1};
            STEP_CLK_OFF: r = '{clk_side: 1'b1, clear_reg: 1'b1, want: 1'b0};
            STEP_RST_OFF: r = '{clk_side: 1'b0, clear_reg: 1'b1, want: 1'b0};
            default:      r = '{clk_side: 1'b1, clear_reg: 1'b0, want: 1'b1};
        endcase
        return r;
    endfunction

endpackage

// File: rtl/prst_addr_sel.sv
module prst_addr_sel
    import prst_pkg::*;
#(
    parameter int unsigned AW            = 16,
    parameter int unsigned CLK_SET_ADDR  = 32'h338,
    parameter int unsigned RST_SET_ADDR  = 32'hA38,
    parameter int unsigned CLK_STAT_ADDR = 32'h531C,
    parameter int unsigned RST_STAT_ADDR = 32'h5A1C
) (
    input  step_e          step_i,
    output logic [AW-1:0]  wr_addr_o,
    output logic [AW-1:0]  rd_addr_o
);
    localparam logic [AW-1:0] CLK_SET_A = AW'(CLK_SET_ADDR);
    localparam logic [AW-1:0] CLK_CLR_A = AW'(CLK_SET_ADDR + CLR_OFFSET);
    localparam logic [AW-1:0] RST_SET_A = AW'(RST_SET_ADDR);
    localparam logic [AW-1:0] RST_CLR_A = AW'(RST_SET_ADDR + CLR_OFFSET);
    localparam logic [AW-1:0] CLK_ST_A  = AW'(CLK_STAT_ADDR);
    localparam logic [AW-1:0] RST_ST_A  = AW'(RST_STAT_ADDR);

    step_info_t info;

    always_comb begin
        info = step_info(step_i);
        if (info.clk_side) begin
            wr_addr_o = info.clear_reg ? CLK_CLR_A : CLK_SET_A;
            rd_addr_o = CLK_ST_A;
        end else begin
            wr_addr_o = info.clear_reg ? RST_CLR_A : RST_SET_A;
            rd_addr_o = RST_ST_A;
        end
    end

endmodule

// File: rtl/prst_poll_timer.sv
module prst_poll_timer #(
    parameter int unsigned LIMIT = 1000000
) (
    input  logic clk,
    input  logic rst,
    input  logic clr_i,
    input  logic tick_i,
    output logic last_o
);
    localparam int unsigned CW = $clog2(LIMIT + 1);
    localparam logic [CW-1:0] LAST_V = CW'(LIMIT - 1);

    logic [CW-1:0] cnt_q;

    assign last_o = (cnt_q == LAST_V);

    always_ff @(posedge clk) begin
        if (rst || clr_i) begin
            cnt_q <= '0;
        end else if (tick_i && !last_o) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // R5: the completed-read count never passes the poll budget
    assert_cnt_bound_R5: assert property (@(posedge clk) disable iff (rst)
        cnt_q < CW'(LIMIT));

endmodule

// File: rtl/prst_fsm.sv
module prst_fsm
    import prst_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       start_i,
    input  logic       rvalid_i,
    input  logic       rbit_i,
    input  logic       poll_last_i,
    output step_e      step_o,
    output logic       busy_o,
    output logic       done_o,
    output logic       err_o,
    output logic [1:0] err_step_o,
    output logic       bus_wr_o,
    output logic       bus_rd_o,
    output logic       poll_clr_o,
    output logic       poll_tick_o
);
    phase_e     phase_q;
    step_e      step_q;
    logic       done_q, err_q;
    logic [1:0] err_step_q;
    logic       hit;

    assign hit         = (rbit_i == step_info(step_q).want);
    assign step_o      = step_q;
    assign busy_o      = (phase_q != PH_IDLE);
    assign bus_wr_o    = (phase_q == PH_WRITE);
    assign bus_rd_o    = (phase_q == PH_RD_REQ);
    assign poll_clr_o  = (phase_q == PH_WRITE);
    assign poll_tick_o = (phase_q == PH_RD_WAIT) && rvalid_i;
    assign done_o      = done_q;
    assign err_o       = err_q;
    assign err_step_o  = err_step_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q    <= PH_IDLE;
            step_q     <= STEP_RST_ON;
            done_q     <= 1'b0;
            err_q      <= 1'b0;
            err_step_q <= 2'd0;
        end else begin
            case (phase_q)
                PH_IDLE: begin
                    if (start_i) begin
                        phase_q    <= PH_WRITE;
                        step_q     <= STEP_RST_ON;
                        done_q     <= 1'b0;
                        err_q      <= 1'b0;
                        err_step_q <= 2'd0;
                    end
                end
                PH_WRITE:  phase_q <= PH_RD_REQ;
                PH_RD_REQ: phase_q <= PH_RD_WAIT;
                default: begin
                    if (rvalid_i) begin
                        if (hit) begin
                            if (step_q == STEP_CLK_ON) begin
                                phase_q <= PH_IDLE;
                                done_q  <= 1'b1;
                            end else begin
                                step_q  <= step_e'(step_q + 2'd1);
                                phase_q <= PH_WRITE;
                            end
                        end else if (poll_last_i) begin
                            phase_q    <= PH_IDLE;
                            err_q      <= 1'b1;
                            err_step_q <= step_q;
                        end else begin
                            phase_q <= PH_RD_REQ;
                        end
                    end
                end
            endcase
        end
    end

    // Tracks a read in flight, used only by the checks below
    logic rd_pend_q;
    always_ff @(posedge clk) begin
        if (rst)           rd_pend_q <= 1'b0;
        else if (bus_rd_o) rd_pend_q <= 1'b1;
        else if (rvalid_i) rd_pend_q <= 1'b0;
    end

    assert_one_read_R10: assert property (@(posedge clk) disable iff (rst)
        bus_rd_o |-> !rd_pend_q);

    assert_wr_then_rd_R4: assert property (@(posedge clk) disable iff (rst)
        bus_wr_o |=> bus_rd_o);

    assert_flags_excl_R9: assert property (@(posedge clk) disable iff (rst)
        !(done_o && err_o));

    assert_flags_hold_R9: assert property (@(posedge clk) disable iff (rst)
        (!busy_o && !start_i) |=> ($stable(done_o) && $stable(err_o)));

    assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (rst)
        !busy_o |-> !(bus_wr_o || bus_rd_o));

    assert_start_ignored_R8: assert property (@(posedge clk) disable iff (rst)
        (busy_o && start_i && bus_wr_o) |=> (bus_rd_o && busy_o));

endmodule

// File: rtl/prst_seq.sv
module prst_seq
    import prst_pkg::*;
#(
    parameter int unsigned AW            = 16,
    parameter int unsigned DW            = 32,
    parameter int unsigned CLK_SET_ADDR  = 32'h338,
    parameter int unsigned RST_SET_ADDR  = 32'hA38,
    parameter int unsigned CLK_STAT_ADDR = 32'h531C,
    parameter int unsigned RST_STAT_ADDR = 32'h5A1C,
    parameter int unsigned POLL_LIMIT    = 1000000
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start_i,
    output logic          busy_o,
    output logic          done_o,
    output logic          err_o,
    output logic [1:0]    err_step_o,
    output logic          bus_wr_o,
    output logic          bus_rd_o,
    output logic [AW-1:0] bus_addr_o,
    output logic [DW-1:0] bus_wdata_o,
    input  logic          bus_rvalid_i,
    input  logic [DW-1:0] bus_rdata_i
);
    step_e         step;
    logic [AW-1:0] wr_addr, rd_addr;
    logic          poll_clr, poll_tick, poll_last;
    logic          unused_rdata;

    assign unused_rdata = ^bus_rdata_i[DW-1:1];

    prst_fsm u_fsm (
        .clk         (clk),
        .rst         (rst),
        .start_i     (start_i),
        .rvalid_i    (bus_rvalid_i),
        .rbit_i      (bus_rdata_i[0]),
        .poll_last_i (poll_last),
        .step_o      (step),
        .busy_o      (busy_o),
        .done_o      (done_o),
        .err_o       (err_o),
        .err_step_o  (err_step_o),
        .bus_wr_o    (bus_wr_o),
        .bus_rd_o    (bus_rd_o),
        .poll_clr_o  (poll_clr),
        .poll_tick_o (poll_tick)
    );

    prst_poll_timer #(.LIMIT(POLL_LIMIT)) u_timer (
        .clk    (clk),
        .rst    (rst),
        .clr_i  (poll_clr),
        .tick_i (poll_tick),
        .last_o (poll_last)
    );

    prst_addr_sel #(
        .AW            (AW),
        .CLK_SET_ADDR  (CLK_SET_ADDR),
        .RST_SET_ADDR  (RST_SET_ADDR),
        .CLK_STAT_ADDR (CLK_STAT_ADDR),
        .RST_STAT_ADDR (RST_STAT_ADDR)
    ) u_addr (
        .step_i    (step),
        .wr_addr_o (wr_addr),
        .rd_addr_o (rd_addr)
    );

    assign bus_addr_o  = bus_wr_o ? wr_addr : rd_addr;
    assign bus_wdata_o = DW'(1);

    // R7: a failure report names the step that was running
    assert_err_step_R7: assert property (@(posedge clk) disable iff (rst)
        $rose(err_o) |-> (err_step_o == $past(step)));

endmodule

// File: tb/tb_prst_seq.sv
`timescale 1ns/1ps
module tb_prst_seq;
    localparam int AW   = 16;
    localparam int DW   = 32;
    localparam int LIM  = 6;
    localparam int RLAT = 2;
    localparam logic [AW-1:0] A_CLK_EN  = 16'h0338;
    localparam logic [AW-1:0] A_CLK_DIS = 16'h033C;
    localparam logic [AW-1:0] A_RST_REQ = 16'h0A38;
    localparam logic [AW-1:0] A_RST_REL = 16'h0A3C;
    localparam logic [AW-1:0] A_CLK_ST  = 16'h531C;
    localparam logic [AW-1:0] A_RST_ST  = 16'h5A1C;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start = 1'b0;
    logic busy, done, err, bus_wr, bus_rd, rvalid;
    logic [1:0] err_step;
    logic [AW-1:0] bus_addr;
    logic [DW-1:0] wdata;
    logic [DW-1:0] rdata;

    always #2.5 clk = ~clk;

    prst_seq #(.AW(AW), .DW(DW), .POLL_LIMIT(LIM)) dut (
        .clk(clk), .rst(rst), .start_i(start),
        .busy_o(busy), .done_o(done), .err_o(err), .err_step_o(err_step),
        .bus_wr_o(bus_wr), .bus_rd_o(bus_rd), .bus_addr_o(bus_addr),
        .bus_wdata_o(wdata), .bus_rvalid_i(rvalid), .bus_rdata_i(rdata)
    );

    int checks = 0;
    int fails  = 0;
    bit finished = 0;

    // Configuration written by the tests only
    int lat [4];
    int run_id = 0;

    // System-control model state, written by the model only
    int seen_id = 0;
    int clk_st, rst_st, clk_tgt, rst_tgt, clk_rem, rst_rem;
    int wcnt, rcnt, order_viol, addr_viol, ovl_viol, data_viol;
    int want, exp_stat, rwait, val;
    bit satisfied, pend;
    logic [AW-1:0] wlog [8];
    logic [AW-1:0] raddr;

    always @(posedge clk) begin
        if (rst) begin
            pend   = 0;
            rvalid <= 1'b0;
            rdata  <= '0;
        end else begin
            rvalid <= 1'b0;
            if (run_id != seen_id) begin
                seen_id = run_id;
                clk_st = 1; rst_st = 0; clk_rem = 0; rst_rem = 0;
                wcnt = 0; rcnt = 0; order_viol = 0; addr_viol = 0;
                ovl_viol = 0; data_viol = 0; satisfied = 1; exp_stat = 0;
            end
            if (bus_wr) begin
                if (!satisfied && wcnt > 0) order_viol++;
                if (wdata != 32'd1) data_viol++;
                if (wcnt < 8) wlog[wcnt] = bus_addr;
                wcnt++;
                satisfied = 0;
                case (bus_addr)
                    A_RST_REQ: begin rst_tgt = 1; rst_rem = lat[0]; want = 1; exp_stat = 2; end
                    A_CLK_DIS: begin clk_tgt = 0; clk_rem = lat[1]; want = 0; exp_stat = 1; end
                    A_RST_REL: begin rst_tgt = 0; rst_rem = lat[2]; want = 0; exp_stat = 2; end
                    A_CLK_EN:  begin clk_tgt = 1; clk_rem = lat[3]; want = 1; exp_stat = 1; end
                    default:   begin addr_viol++; exp_stat = 0; end
                endcase
            end
            if (bus_rd) begin
                if (pend || bus_wr) ovl_viol++;
                if (!((exp_stat == 1 && bus_addr == A_CLK_ST) ||
                      (exp_stat == 2 && bus_addr == A_RST_ST))) addr_viol++;
                pend  = 1;
                rwait = RLAT;
                raddr = bus_addr;
                rcnt++;
            end else if (pend) begin
                if (rwait > 1) begin
                    rwait--;
                end else begin
                    if (raddr == A_CLK_ST) begin
                        if (clk_rem > 0) begin clk_rem--; if (clk_rem == 0) clk_st = clk_tgt; end
                        val = clk_st;
                    end else begin
                        if (rst_rem > 0) begin rst_rem--; if (rst_rem == 0) rst_st = rst_tgt; end
                        val = rst_st;
                    end
                    rdata  <= DW'(val) | 32'hFFFF_FFF0 & ~32'h1;
                    rvalid <= 1'b1;
                    pend   = 0;
                    if (val == want) satisfied = 1;
                end
            end
        end
    end

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic report;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    endtask

    task automatic prep(int l0, int l1, int l2, int l3);
        lat[0] = l0; lat[1] = l1; lat[2] = l2; lat[3] = l3;
        run_id++;
        @(negedge clk);
        @(negedge clk);
    endtask

    // Pulses start; optionally pulses it again while busy at given delays
    task automatic launch(int again1, int again2);
        int n;
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        chk("R2 busy after start", busy, 1);
        chk("R9 done cleared at start", done, 0);
        chk("R9 err cleared at start", err, 0);
        n = 0;
        while (busy && n < 3000) begin
            @(negedge clk);
            n++;
            start = (n == again1 || n == again2);
        end
        start = 1'b0;
        chk("R2 sequence ends", busy, 0);
    endtask

    task automatic t_reset;
        chk("R1 busy", busy, 0);
        chk("R1 done", done, 0);
        chk("R1 err", err, 0);
        chk("R1 wr", bus_wr, 0);
        chk("R1 rd", bus_rd, 0);
    endtask

    task automatic t_normal;
        prep(2, 3, 1, 4);
        launch(-1, -1);
        chk("R2 done", done, 1);
        chk("R9 no err", err, 0);
        chk("R2 write count", wcnt, 4);
        chk("R3 write 1 reset request", wlog[0], A_RST_REQ);
        chk("R3 write 2 clock disable", wlog[1], A_CLK_DIS);
        chk("R3 write 3 reset release", wlog[2], A_RST_REL);
        chk("R3 write 4 clock enable", wlog[3], A_CLK_EN);
        chk("R3 status addresses", addr_viol, 0);
        chk("R2 write data", data_viol, 0);
        chk("R4 read count", rcnt, 10);
        chk("R4 write after match", order_viol, 0);
        chk("R10 single read", ovl_viol, 0);
        chk("R4 clock on at end", clk_st, 1);
        chk("R4 reset off at end", rst_st, 0);
    endtask

    task automatic t_hold;
        repeat (20) @(negedge clk);
        chk("R9 done held", done, 1);
        chk("R9 err stays low", err, 0);
    endtask

    task automatic t_last_poll;
        prep(LIM, LIM, LIM, LIM);
        launch(-1, -1);
        chk("R6 match on last poll done", done, 1);
        chk("R6 no timeout", err, 0);
        chk("R6 writes", wcnt, 4);
        chk("R6 reads", rcnt, 4 * LIM);
        chk("R10 single read", ovl_viol, 0);
    endtask

    task automatic t_timeout(int k);
        int l [4];
        for (int i = 0; i < 4; i++) l[i] = (i == k) ? LIM + 1 : 1;
        prep(l[0], l[1], l[2], l[3]);
        launch(-1, -1);
        chk("R5 err raised", err, 1);
        chk("R9 done low on err", done, 0);
        chk("R7 err step", err_step, k);
        chk("R5 writes stop", wcnt, k + 1);
        chk("R5 reads stop", rcnt, k + LIM);
        repeat (10) @(negedge clk);
        chk("R5 no writes after abort", wcnt, k + 1);
        chk("R9 err held", err, 1);
    endtask

    task automatic t_busy_start;
        prep(3, 3, 3, 3);
        launch(1, 15);
        chk("R8 done", done, 1);
        chk("R8 write count", wcnt, 4);
        chk("R8 read count", rcnt, 12);
        chk("R8 order", wlog[0], A_RST_REQ);
        chk("R8 no restart", order_viol, 0);
        repeat (5) @(negedge clk);
        chk("R8 stays idle", busy, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog actual=hung expected=finish");
            report();
            $finish;
        end
    end

    initial begin
        lat[0] = 1; lat[1] = 1; lat[2] = 1; lat[3] = 1;
        repeat (4) @(posedge clk);
        @(negedge clk) rst = 1'b0;
        t_reset();
        t_normal();
        t_hold();
        t_last_poll();
        for (int k = 0; k < 4; k++) t_timeout(k);
        t_busy_start();
        finished = 1;
        report();
        $finish;
    end

endmodule